// File: doc/BRIEF.md
# Display Timing Source Switch Controller

This block decides where a display pipeline takes its timing from. The two sources are an internal clock generator and an external pixel interface that runs on its own dot clock. Software writes a two-bit display-mode code and a RAM-path select bit through a plain register write port. These values sit in shadow registers. They move into the live registers only when the source that is currently active reports the end of a frame. A change therefore never takes effect part-way through a frame.

Once the live mode selects the external interface, three outputs change. The timing tick comes from the dot-clock tick instead of the internal tick. The partial-display, scroll and interlace enables are held low, whatever their register values are. A registered error flag goes high when the external mode is live and the high-speed write bit is clear. All ports are plain control and status signals. No stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `dsm_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the live mode to 00 and the live RAM select to 0, clears pending and the error flag, and lets the feature requests pass through unmasked.
- R2: A write with mode code 00 or 01 is stored in the shadow registers and sets pending from the next cycle. The live mode and live RAM select do not change at that point.
- R3: The shadow-to-live transfer happens only on the frame-end strobe of the live source: int_frame_end when the live mode is 00, ext_frame_end when it is 01. A strobe from the other source has no effect.
- R4: On a transfer, from the next cycle the live mode and live RAM select hold the shadow values and pending is low.
- R5: A write with a reserved mode code (10 or 11) is dropped. It does not set pending and does not change the shadow contents, so an earlier pending value is still the one applied.
- R6: Bit 0 of feat_req/feat_en is partial display, bit 1 is scroll and bit 2 is interlace. While the live mode is 01, feat_en is all zeros. Otherwise feat_en equals feat_req.
- R7: ref_tick follows dot_tick while the live mode is 01, and follows int_tick otherwise.
- R8: cfg_err is registered. One cycle after a cycle in which the live mode is 01 and hs_write is 0, cfg_err is 1. It is 0 after any other cycle.
- R9: A legal write in the same cycle as a live frame-end strobe does not transfer on that strobe. Pending stays high, and the new value waits for the next live frame end.
- R10: When several legal writes arrive before a transfer, the last one is the value applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_mode | input | 2 | Display-mode code to write (00 internal, 01 external, 1x reserved) |
| wr_ram | input | 1 | RAM-path select to write |
| hs_write | input | 1 | High-speed write bit, live level |
| int_frame_end | input | 1 | Frame-end strobe from the internal timing source |
| ext_frame_end | input | 1 | Frame-end strobe from the external pixel interface |
| int_tick | input | 1 | Internal oscillator timing tick |
| dot_tick | input | 1 | External dot-clock timing tick |
| feat_req | input | 3 | Feature enable register values (partial, scroll, interlace) |
| act_mode | output | 2 | Live display-mode code |
| act_ram | output | 1 | Live RAM-path select |
| ext_active | output | 1 | High while the live mode is external |
| pending | output | 1 | Shadow holds a value not yet applied |
| ref_tick | output | 1 | Selected timing tick for gate and panel timing counters |
| feat_en | output | 3 | Feature enables after masking |
| cfg_err | output | 1 | External mode live with high-speed write bit clear |

## Verification
The assertions assume that the frame-end strobes are single-cycle pulses aligned to clk and that wr_en is sampled as one write per cycle. They also assume that nothing drives the inputs during reset. The stimulus changes inputs only on the falling clock edge, pulses each strobe for exactly one cycle, and puts the collision case (a write together with a live frame end) and the wrong-source strobe in separate dedicated cycles. That way each rule is exercised on its own.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    DM_INT  = 2'b00,
    DM_EXT  = 2'b01,
    DM_RSV2 = 2'b10,
    DM_RSV3 = 2'b11
  } dmode_t;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m == DM_INT) || (m == DM_EXT);
  endfunction
endpackage

// File: rtl/dsm_shadow.sv
module dsm_shadow
  import dsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              wr_ram,
  input  logic              xfer,
  output dmode_t            sh_mode,
  output logic              sh_ram,
  output logic              pend,
  output logic              wr_ok
);
  assign wr_ok = wr_en && mode_legal(wr_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_mode <= DM_INT;
      sh_ram  <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (wr_ok) begin
        sh_mode <= dmode_t'(wr_mode);
        sh_ram  <= wr_ram;
      end
      if (wr_ok)     pend <= 1'b1;
      else if (xfer) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dsm_active.sv
module dsm_active
  import dsm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  dmode_t sh_mode,
  input  logic   sh_ram,
  input  logic   pend,
  input  logic   wr_ok,
  input  logic   int_fe,
  input  logic   ext_fe,
  input  logic   hs_write,
  output dmode_t live_mode,
  output logic   live_ram,
  output logic   live_ext,
  output logic   xfer,
  output logic   err_q
);
  logic fe_live;

  assign live_ext = (live_mode == DM_EXT);
  assign fe_live  = live_ext ? ext_fe : int_fe;
  assign xfer     = pend && fe_live && !wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_mode <= DM_INT;
      live_ram  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (xfer) begin
        live_mode <= sh_mode;
        live_ram  <= sh_ram;
      end
      err_q <= live_ext && !hs_write;
    end
  end
endmodule

// File: rtl/dsm_route.sv
module dsm_route #(
  parameter int NFEAT = 3
) (
  input  logic             live_ext,
  input  logic             int_tick,
  input  logic             dot_tick,
  input  logic [NFEAT-1:0] feat_req,
  output logic [NFEAT-1:0] feat_en,
  output logic             ref_tick
);
  assign ref_tick = live_ext ? dot_tick : int_tick;

  for (genvar g = 0; g < NFEAT; g++) begin : g_mask
    assign feat_en[g] = feat_req[g] & ~live_ext;
  end
endmodule

// File: rtl/dsm_mode_ctrl.sv
module dsm_mode_ctrl
  import dsm_pkg::*;
#(
  parameter int NFEAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              wr_ram,
  input  logic              hs_write,
  input  logic              int_frame_end,
  input  logic              ext_frame_end,
  input  logic              int_tick,
  input  logic              dot_tick,
  input  logic [NFEAT-1:0]  feat_req,
  output logic [MODE_W-1:0] act_mode,
  output logic              act_ram,
  output logic              ext_active,
  output logic              pending,
  output logic              ref_tick,
  output logic [NFEAT-1:0]  feat_en,
  output logic              cfg_err
);
  dmode_t sh_mode, live_mode;
  logic   sh_ram, wr_ok, xfer, live_ext;

  dsm_shadow u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .wr_ram(wr_ram),
    .xfer(xfer), .sh_mode(sh_mode), .sh_ram(sh_ram), .pend(pending), .wr_ok(wr_ok)
  );

  dsm_active u_active (
    .clk(clk), .rst(rst), .sh_mode(sh_mode), .sh_ram(sh_ram), .pend(pending),
    .wr_ok(wr_ok), .int_fe(int_frame_end), .ext_fe(ext_frame_end),
    .hs_write(hs_write), .live_mode(live_mode), .live_ram(act_ram),
    .live_ext(live_ext), .xfer(xfer), .err_q(cfg_err)
  );

  dsm_route #(.NFEAT(NFEAT)) u_route (
    .live_ext(live_ext), .int_tick(int_tick), .dot_tick(dot_tick),
    .feat_req(feat_req), .feat_en(feat_en), .ref_tick(ref_tick)
  );

  assign act_mode   = live_mode;
  assign ext_active = live_ext;
endmodule

// File: rtl/dsm_mode_ctrl_chk.sv
module dsm_mode_ctrl_chk #(
  parameter int NFEAT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_mode,
  input logic             hs_write,
  input logic             int_frame_end,
  input logic             ext_frame_end,
  input logic             int_tick,
  input logic             dot_tick,
  input logic [NFEAT-1:0] feat_req,
  input logic [1:0]       act_mode,
  input logic             act_ram,
  input logic             ext_active,
  input logic             pending,
  input logic             ref_tick,
  input logic [NFEAT-1:0] feat_en,
  input logic             cfg_err
);
  logic fe_sel, legal_wr;
  assign fe_sel   = (act_mode == 2'b01) ? ext_frame_end : int_frame_end;
  assign legal_wr = wr_en && !wr_mode[1];

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    pending && !fe_sel |=> pending);
  p_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !(pending && fe_sel) |=> $stable(act_mode) && $stable(act_ram));
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    pending && fe_sel && !legal_wr |=> !pending);
  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    !pending && wr_en && wr_mode[1] |=> !pending);
  p_legal_mode_r5: assert property (@(posedge clk) disable iff (rst)
    !act_mode[1]);
  p_mask_r6: assert property (@(posedge clk) disable iff (rst)
    ext_active |-> feat_en == '0);
  p_tick_r7: assert property (@(posedge clk) disable iff (rst)
    ext_active |-> ref_tick == dot_tick);
  p_err_r8: assert property (@(posedge clk) disable iff (rst)
    ext_active && !hs_write |=> cfg_err);
  p_collide_r9: assert property (@(posedge clk) disable iff (rst)
    legal_wr |=> pending);
endmodule

bind dsm_mode_ctrl dsm_mode_ctrl_chk #(.NFEAT(NFEAT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .hs_write(hs_write),
  .int_frame_end(int_frame_end), .ext_frame_end(ext_frame_end),
  .int_tick(int_tick), .dot_tick(dot_tick), .feat_req(feat_req),
  .act_mode(act_mode), .act_ram(act_ram), .ext_active(ext_active),
  .pending(pending), .ref_tick(ref_tick), .feat_en(feat_en), .cfg_err(cfg_err)
);

// File: tb/test_dsm_mode_ctrl.sv
module test_dsm_mode_ctrl;
  logic clk = 1'b0;
  logic rst;
  logic wr_en, wr_ram, hs_write, int_frame_end, ext_frame_end, int_tick, dot_tick;
  logic [1:0] wr_mode, act_mode;
  logic [2:0] feat_req, feat_en;
  logic act_ram, ext_active, pending, ref_tick, cfg_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dsm_mode_ctrl i_dsm_mode_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .wr_ram(wr_ram),
    .hs_write(hs_write), .int_frame_end(int_frame_end), .ext_frame_end(ext_frame_end),
    .int_tick(int_tick), .dot_tick(dot_tick), .feat_req(feat_req),
    .act_mode(act_mode), .act_ram(act_ram), .ext_active(ext_active),
    .pending(pending), .ref_tick(ref_tick), .feat_en(feat_en), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] wm;
    logic       wr;
    logic       ife;
    logic       efe;
    logic       hs;
    logic [2:0] feat;
    logic [1:0] em;
    logic       er;
    logic       ep;
    logic [2:0] ef;
    logic       ee;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 2'b00, 1'b0, 1'b0, 3'b111, 1'b0}, // R6 idle internal
    '{1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 3'b101, 2'b00, 1'b0, 1'b1, 3'b101, 1'b0}, // R2 write ext
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 3'b101, 2'b00, 1'b0, 1'b1, 3'b101, 1'b0}, // R3 wrong strobe
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 3'b111, 2'b01, 1'b1, 1'b0, 3'b000, 1'b0}, // R4 transfer
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 2'b01, 1'b1, 1'b0, 3'b000, 1'b1}, // R8 err set
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 2'b01, 1'b1, 1'b0, 3'b000, 1'b0}, // R8 err clear
    '{1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 2'b01, 1'b1, 1'b0, 3'b000, 1'b0}, // R5 reserved
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 3'b111, 2'b01, 1'b1, 1'b0, 3'b000, 1'b0}, // R3 no pending
    '{1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0}, // R2 write int
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 3'b111, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0}, // R3 wrong strobe
    '{1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0}, // R9 collision
    '{1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0}, // R10 rewrite
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 3'b011, 2'b00, 1'b0, 1'b0, 3'b011, 1'b0}, // R10 applied
    '{1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 3'b011, 2'b00, 1'b0, 1'b0, 3'b011, 1'b0}  // R5 reserved
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_mode = 2'b00; wr_ram = 0; int_frame_end = 0; ext_frame_end = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); hs_write = 1; int_tick = 0; dot_tick = 0; feat_req = 3'b111; rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    chk("R1 mode", {6'd0, act_mode}, 8'd0);
    chk("R1 pending", {7'd0, pending}, 8'd0);
    chk("R1 err", {7'd0, cfg_err}, 8'd0);
    chk("R1 feat", {5'd0, feat_en}, 8'd7);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i].we; wr_mode = VEC[i].wm; wr_ram = VEC[i].wr;
      int_frame_end = VEC[i].ife; ext_frame_end = VEC[i].efe;
      hs_write = VEC[i].hs; feat_req = VEC[i].feat;
      step();
      chk("R2/R3/R4 mode", {6'd0, act_mode}, {6'd0, VEC[i].em});
      chk("R4 ram", {7'd0, act_ram}, {7'd0, VEC[i].er});
      chk("R5/R9 pending", {7'd0, pending}, {7'd0, VEC[i].ep});
      chk("R6 feat", {5'd0, feat_en}, {5'd0, VEC[i].ef});
      chk("R8 err", {7'd0, cfg_err}, {7'd0, VEC[i].ee});
    end

    // R7 internal routing
    @(negedge clk); idle(); hs_write = 1; int_tick = 1; dot_tick = 0; #1;
    chk("R7 int tick", {7'd0, ref_tick}, 8'd1);
    int_tick = 0; dot_tick = 1; #1;
    chk("R7 int tick", {7'd0, ref_tick}, 8'd0);

    // R5: reserved write after legal write keeps the legal value
    @(negedge clk); wr_en = 1; wr_mode = 2'b01; wr_ram = 0;
    step();
    @(negedge clk); wr_mode = 2'b11; wr_ram = 1;
    step();
    @(negedge clk); idle(); int_frame_end = 1;
    step();
    chk("R5 kept mode", {6'd0, act_mode}, 8'd1);
    chk("R5 kept ram", {7'd0, act_ram}, 8'd0);

    // R7 external routing
    @(negedge clk); idle(); int_tick = 1; dot_tick = 0; #1;
    chk("R7 dot tick", {7'd0, ref_tick}, 8'd0);
    int_tick = 0; dot_tick = 1; #1;
    chk("R7 dot tick", {7'd0, ref_tick}, 8'd1);

    // R1: reset in external mode with a write pending
    @(negedge clk); wr_en = 1; wr_mode = 2'b00;
    step();
    @(negedge clk); idle(); rst = 1;
    step();
    @(negedge clk); rst = 0; #1;
    chk("R1 mode after reset", {6'd0, act_mode}, 8'd0);
    chk("R1 pending after reset", {7'd0, pending}, 8'd0);
    chk("R7 after reset", {7'd0, ref_tick}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule